// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block sits between an interrupt source controller and a single processor. It keeps one pending slot. The slot holds a 32-bit pending word, made of a current processor priority byte and a 24-bit source number, together with the priority of the pending interrupt. A smaller priority number always wins. When the source controller offers a source that beats both the processor priority and whatever is already pending, the block stores it and raises the processor interrupt line. It also sends back as a reject any source it loses or any source it displaces, so the source layer can offer that source again later.

Software works the block through a one-cycle register port with four operations: set processor priority, set inter-processor priority, accept (read and acknowledge) and end-of-interrupt. An inter-processor interrupt is injected under the reserved source number 2 whenever its priority beats the processor priority. When the slot becomes empty, for example after an end-of-interrupt or after a processor priority change that opens the gate, the block asks the source layer to resend.

All notifications toward the source layer and the processor are registered. They pulse for one cycle, in the cycle after the operation or request that caused them.

Top module: `intr_present_ctrl`

## Requirements
- R1: After a synchronous reset the pending word and pending priority are zero, the inter-processor priority is 0xFF, irq_out is low and no notification pulses.
- R2: The pending word carries the processor priority in bits 31:24 and the pending source in bits 23:0 (zero = empty). An offered request is stored, and irq_out rises in the next cycle, only when its priority is numerically below the processor priority and, if the slot is busy, below the pending priority.
- R3: A losing request is returned as a reject with its own source number. A winning request that displaces a pending source returns the displaced number as a reject. At most one reject pulses per cycle.
- R4: Accept (op code 2) returns the pending word on rd_data with rd_valid. It then sets the processor priority to the pending priority, clears the source field and lowers irq_out.
- R5: Set processor priority (op code 0, value in bits 31:24) to a more favoured value while a source is pending at a priority equal to or less favoured than the new value clears the slot, lowers irq_out and rejects that source. Otherwise the slot is kept.
- R6: Set processor priority to an equal or less favoured value with an empty slot pulses resend_req. If the inter-processor priority is below the new processor priority, the slot is also loaded with source 2 at that priority and irq_out rises.
- R7: Set inter-processor priority (op code 1, value in bits 7:0) stores the value. If the value is below the processor priority and no source is pending at an equal or more favoured priority, the block rejects any pending source, loads source 2 with this priority and raises irq_out.
- R8: End-of-interrupt (op code 3) copies bits 31:24 into the processor priority and pulses eoi_valid with eoi_src = bits 23:0. If the slot is empty it then performs the resend of R6 against the new priority.
- R9: A register operation takes precedence over a request in the same cycle. req_ready is low in that cycle and the request has no effect.
- R10: irq_out is high exactly when the source field of the pending word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Source controller offers a source this cycle |
| req_ready | output | 1 | Offer is taken this cycle (low when an operation is present) |
| req_src | input | 24 | Offered source number (never zero) |
| req_prio | input | 8 | Offered priority |
| op_valid | input | 1 | Register operation this cycle |
| op_kind | input | 2 | 0 set priority, 1 set IPI priority, 2 accept, 3 end-of-interrupt |
| op_data | input | 32 | Operation value |
| rd_valid | output | 1 | Accept result valid |
| rd_data | output | 32 | Pending word captured by accept |
| rej_valid | output | 1 | Reject pulse to the source controller |
| rej_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Ask the source controller to resend |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source controller |
| eoi_src | output | 24 | Source number being completed |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
A register operation and a source offer can arrive in the same cycle. The operation must win, and the offer must leave no trace. The bench provokes this both on purpose and in many random cycles where both valids are high. It judges the result from req_ready in that cycle and from the reject, irq_out and later accept read-back, all compared with a bench model that discards the offer. It also pairs accepts with colliding offers whose priority would have won, so a design that took the offer would show a raised irq_out or a non-empty read.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    localparam src_t  IPI_SRC    = src_t'(2);
    localparam prio_t PRIO_LEAST = '1;

    typedef enum logic [1:0] {
        OP_SET_CPPR = 2'd0,
        OP_SET_IPI  = 2'd1,
        OP_ACCEPT   = 2'd2,
        OP_EOI      = 2'd3
    } op_kind_e;

    // pending word: processor priority on top, source number below
    typedef struct packed {
        prio_t cppr;
        src_t  src;
    } pend_word_t;

    typedef struct packed {
        pend_word_t word;
        prio_t      pprio;
        prio_t      mfrr;
        logic       irq;
    } ipc_state_t;

    typedef struct packed {
        logic       rej_v;
        src_t       rej_src;
        logic       resend;
        logic       eoi_v;
        src_t       eoi_src;
        logic       rd_v;
        pend_word_t rd_word;
    } ipc_notify_t;

    function automatic logic beats(prio_t a, prio_t b);
        return a < b;
    endfunction

    function automatic logic slot_busy(src_t s);
        return s != '0;
    endfunction

endpackage

// File: rtl/ipc_req_arbiter.sv
module ipc_req_arbiter
    import ipc_pkg::*;
(
    input  pend_word_t word,
    input  prio_t      pprio,
    input  src_t       req_src,
    input  prio_t      req_prio,
    output logic       take,
    output logic       bounce,
    output src_t       bounce_src
);
    logic gated_by_cpu;
    logic gated_by_slot;

    always_comb begin
        gated_by_cpu  = !beats(req_prio, word.cppr);
        gated_by_slot = slot_busy(word.src) && !beats(req_prio, pprio);
        take          = !(gated_by_cpu || gated_by_slot);
        // loser goes back; or the winner pushes the old occupant back
        bounce        = !take || slot_busy(word.src);
        bounce_src    = take ? word.src : req_src;
    end
endmodule

// File: rtl/ipc_ipi_check.sv
module ipc_ipi_check
    import ipc_pkg::*;
(
    input  src_t  cur_src,
    input  prio_t pprio,
    input  prio_t mfrr,
    input  prio_t cppr,
    output logic  fire,
    output logic  bump
);
    logic open_gate;
    logic held_off;

    always_comb begin
        open_gate = beats(mfrr, cppr);
        held_off  = slot_busy(cur_src) && !beats(mfrr, pprio);
        fire      = open_gate && !held_off;
        bump      = fire && slot_busy(cur_src);
    end
endmodule

// File: rtl/ipc_op_engine.sv
module ipc_op_engine
    import ipc_pkg::*;
(
    input  ipc_state_t       cur,
    input  op_kind_e         kind,
    input  logic [WORD_W-1:0] data,
    output ipc_state_t       nxt,
    output ipc_notify_t      ntf
);
    prio_t new_cppr;
    prio_t sel_mfrr;
    prio_t sel_cppr;
    logic  ipi_fire;
    logic  ipi_bump;
    logic  do_resend;

    always_comb begin
        new_cppr = data[WORD_W-1 -: PRIO_W];
        sel_mfrr = (kind == OP_SET_IPI) ? data[PRIO_W-1:0] : cur.mfrr;
        sel_cppr = (kind == OP_SET_IPI || kind == OP_ACCEPT) ? cur.word.cppr : new_cppr;
    end

    ipc_ipi_check u_ipi (
        .cur_src (cur.word.src),
        .pprio   (cur.pprio),
        .mfrr    (sel_mfrr),
        .cppr    (sel_cppr),
        .fire    (ipi_fire),
        .bump    (ipi_bump)
    );

    always_comb begin
        nxt       = cur;
        ntf       = '0;
        do_resend = 1'b0;
        unique case (kind)
            OP_SET_CPPR: begin
                nxt.word.cppr = new_cppr;
                if (beats(new_cppr, cur.word.cppr)) begin
                    if (slot_busy(cur.word.src) && !beats(cur.pprio, new_cppr)) begin
                        nxt.word.src = '0;
                        nxt.irq      = 1'b0;
                        ntf.rej_v    = 1'b1;
                        ntf.rej_src  = cur.word.src;
                    end
                end else if (!slot_busy(cur.word.src)) begin
                    do_resend = 1'b1;
                end
            end
            OP_SET_IPI: begin
                nxt.mfrr = sel_mfrr;
                if (ipi_fire) begin
                    ntf.rej_v    = ipi_bump;
                    ntf.rej_src  = cur.word.src;
                    nxt.word.src = IPI_SRC;
                    nxt.pprio    = sel_mfrr;
                    nxt.irq      = 1'b1;
                end
            end
            OP_ACCEPT: begin
                ntf.rd_v      = 1'b1;
                ntf.rd_word   = cur.word;
                nxt.word.cppr = cur.pprio;
                nxt.word.src  = '0;
                nxt.irq       = 1'b0;
            end
            OP_EOI: begin
                nxt.word.cppr = new_cppr;
                ntf.eoi_v     = 1'b1;
                ntf.eoi_src   = data[SRC_W-1:0];
                do_resend     = !slot_busy(cur.word.src);
            end
            default: ;
        endcase
        // resend only runs with an empty slot, so the IPI check never bumps here
        if (do_resend) begin
            ntf.resend = 1'b1;
            if (ipi_fire) begin
                nxt.word.src = IPI_SRC;
                nxt.pprio    = sel_mfrr;
                nxt.irq      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl
    import ipc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [23:0] req_src,
    input  logic [7:0]  req_prio,
    input  logic        op_valid,
    input  logic [1:0]  op_kind,
    input  logic [31:0] op_data,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        rej_valid,
    output logic [23:0] rej_src,
    output logic        resend_req,
    output logic        eoi_valid,
    output logic [23:0] eoi_src,
    output logic        irq_out
);
    ipc_state_t  state_q, state_d, eng_state;
    ipc_notify_t ntf_q, ntf_d, eng_ntf;
    logic        arb_take, arb_bounce;
    src_t        arb_bounce_src;

    ipc_req_arbiter u_arb (
        .word       (state_q.word),
        .pprio      (state_q.pprio),
        .req_src    (req_src),
        .req_prio   (req_prio),
        .take       (arb_take),
        .bounce     (arb_bounce),
        .bounce_src (arb_bounce_src)
    );

    ipc_op_engine u_eng (
        .cur  (state_q),
        .kind (op_kind_e'(op_kind)),
        .data (op_data),
        .nxt  (eng_state),
        .ntf  (eng_ntf)
    );

    assign req_ready = !op_valid;

    always_comb begin
        state_d = state_q;
        ntf_d   = '0;
        if (op_valid) begin
            state_d = eng_state;
            ntf_d   = eng_ntf;
        end else if (req_valid) begin
            if (arb_take) begin
                state_d.word.src = req_src;
                state_d.pprio    = req_prio;
                state_d.irq      = 1'b1;
            end
            ntf_d.rej_v   = arb_bounce;
            ntf_d.rej_src = arb_bounce_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.word  <= '0;
            state_q.pprio <= '0;
            state_q.mfrr  <= PRIO_LEAST;
            state_q.irq   <= 1'b0;
            ntf_q         <= '0;
        end else begin
            state_q <= state_d;
            ntf_q   <= ntf_d;
        end
    end

    assign irq_out    = state_q.irq;
    assign rd_valid   = ntf_q.rd_v;
    assign rd_data    = ntf_q.rd_word;
    assign rej_valid  = ntf_q.rej_v;
    assign rej_src    = ntf_q.rej_src;
    assign resend_req = ntf_q.resend;
    assign eoi_valid  = ntf_q.eoi_v;
    assign eoi_src    = ntf_q.eoi_src;

    AST_IRQ_TRACKS_SLOT: assert property (@(posedge clk) disable iff (rst)
        irq_out == (state_q.word.src != '0)); // R10
    AST_REJECT_NAMES_SOURCE: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> rej_src != '0); // R3
    AST_ACCEPT_RETURNS_WORD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_ACCEPT) |=> (rd_valid && !irq_out && rd_data == $past(state_q.word))); // R4
    AST_OP_BEATS_REQ: assert property (@(posedge clk) disable iff (rst)
        (op_valid && req_valid && op_kind == OP_ACCEPT) |=> !irq_out); // R9
    AST_IPI_PRIO_STORED: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_SET_IPI) |=> state_q.mfrr == $past(op_data[7:0])); // R7
    AST_EOI_ECHOES: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_EOI) |=> (eoi_valid && eoi_src == $past(op_data[23:0]))); // R8
    AST_EOI_SETS_CPPR: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_EOI) |=> state_q.word.cppr == $past(op_data[31:24])); // R8
endmodule

// File: tb/tb_intr_present_ctrl.sv
module tb_intr_present_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [23:0] req_src;
    logic [7:0]  req_prio;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [31:0] op_data;
    logic        rd_valid, rej_valid, resend_req, eoi_valid, irq_out;
    logic [31:0] rd_data;
    logic [23:0] rej_src, eoi_src;

    intr_present_ctrl dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_prio(req_prio),
        .op_valid(op_valid), .op_kind(op_kind), .op_data(op_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the requirements
    logic [7:0]  m_cppr, m_pp, m_mfrr;
    logic [23:0] m_src;
    logic        e_rej_v, e_resend, e_eoi_v, e_rd_v;
    logic [23:0] e_rej, e_eoi;
    logic [31:0] e_rd;
    string       t_rej, t_irq;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        m_cppr = 8'h00; m_pp = 8'h00; m_mfrr = 8'hFF; m_src = 24'h0;
    endtask

    task automatic m_resend();
        e_resend = 1'b1;
        t_irq = "R6";
        if (m_mfrr < m_cppr) begin m_src = 24'd2; m_pp = m_mfrr; end
    endtask

    task automatic model(input logic ov, input logic [1:0] k, input logic [31:0] d,
                         input logic rv, input logic [23:0] s, input logic [7:0] p);
        e_rej_v = 0; e_rej = 0; e_resend = 0; e_eoi_v = 0; e_eoi = 0; e_rd_v = 0; e_rd = 0;
        t_rej = "R3"; t_irq = "R10";
        if (ov) begin
            case (k)
                2'd0: begin
                    t_rej = "R5"; t_irq = "R5";
                    if (d[31:24] < m_cppr) begin
                        if (m_src != 0 && d[31:24] <= m_pp) begin
                            e_rej_v = 1; e_rej = m_src; m_src = 0;
                        end
                        m_cppr = d[31:24];
                    end else begin
                        m_cppr = d[31:24];
                        if (m_src == 0) m_resend();
                    end
                end
                2'd1: begin
                    t_rej = "R7"; t_irq = "R7";
                    m_mfrr = d[7:0];
                    if (m_mfrr < m_cppr && !(m_src != 0 && m_pp <= m_mfrr)) begin
                        if (m_src != 0) begin e_rej_v = 1; e_rej = m_src; end
                        m_src = 24'd2; m_pp = m_mfrr;
                    end
                end
                2'd2: begin
                    t_irq = "R4";
                    e_rd_v = 1; e_rd = {m_cppr, m_src};
                    m_cppr = m_pp; m_src = 0;
                end
                default: begin
                    t_irq = "R8";
                    m_cppr = d[31:24];
                    e_eoi_v = 1; e_eoi = d[23:0];
                    if (m_src == 0) m_resend();
                end
            endcase
        end else if (rv) begin
            t_irq = "R2";
            if (p >= m_cppr || (m_src != 0 && m_pp <= p)) begin
                e_rej_v = 1; e_rej = s;
            end else begin
                if (m_src != 0) begin e_rej_v = 1; e_rej = m_src; end
                m_src = s; m_pp = p;
            end
        end
    endtask

    task automatic compare();
        chk(t_irq, "irq_out", {31'd0, irq_out}, {31'd0, m_src != 0});
        chk(t_rej, "rej_valid", {31'd0, rej_valid}, {31'd0, e_rej_v});
        if (e_rej_v) chk(t_rej, "rej_src", {8'd0, rej_src}, {8'd0, e_rej});
        chk("R6", "resend_req", {31'd0, resend_req}, {31'd0, e_resend});
        chk("R8", "eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi_v});
        if (e_eoi_v) chk("R8", "eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi});
        chk("R4", "rd_valid", {31'd0, rd_valid}, {31'd0, e_rd_v});
        if (e_rd_v) chk("R4", "rd_data", rd_data, e_rd);
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(input logic ov, input logic [1:0] k, input logic [31:0] d,
                        input logic rv, input logic [23:0] s, input logic [7:0] p);
        op_valid = ov; op_kind = k; op_data = d;
        req_valid = rv; req_src = s; req_prio = p;
        #1;
        if (rv) chk("R9", "req_ready", {31'd0, req_ready}, {31'd0, !ov});
        model(ov, k, d, rv, s, p);
        @(negedge clk);
        compare();
    endtask

    function automatic logic [7:0] rprio();
        return ($urandom % 8 == 0) ? 8'hFF : 8'($urandom % 8);
    endfunction

    function automatic logic [23:0] rsrc();
        return 24'(3 + $urandom % 12);
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7341));
        rst = 1; op_valid = 0; op_kind = 0; op_data = 0; req_valid = 0; req_src = 0; req_prio = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state visible at the ports
        chk("R1", "irq_out", {31'd0, irq_out}, 32'd0);
        chk("R1", "rej_valid", {31'd0, rej_valid}, 32'd0);
        chk("R1", "resend_req", {31'd0, resend_req}, 32'd0);
        chk("R1", "rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R1", "eoi_valid", {31'd0, eoi_valid}, 32'd0);
        step(1, 2'd2, 32'h0, 0, 0, 0);               // R1 accept reads zero word
        step(1, 2'd3, 32'hFF00_0000, 0, 0, 0);       // R1 IPI priority FF: no IPI on resend
        step(0, 0, 0, 1, 24'd5, 8'd4);               // R2 win
        step(0, 0, 0, 1, 24'd6, 8'd4);               // R3 equal loses
        step(0, 0, 0, 1, 24'd7, 8'd2);               // R3 displace 5
        step(1, 2'd2, 32'h0, 1, 24'd9, 8'd1);        // R9 collision with accept
        step(1, 2'd3, 32'hFF00_0007, 0, 0, 0);       // R8
        step(0, 0, 0, 1, 24'd8, 8'd3);
        step(1, 2'd0, 32'h0300_0000, 0, 0, 0);       // R5 clear and reject 8
        step(1, 2'd1, 32'h0000_0005, 0, 0, 0);       // R7 gated
        step(1, 2'd0, 32'h0600_0000, 0, 0, 0);       // R6 resend with IPI load
        step(1, 2'd1, 32'h0000_0001, 0, 0, 0);       // R7 bump IPI
        step(1, 2'd2, 32'h0, 0, 0, 0);               // R4 read 06000002
        step(1, 2'd0, 32'h0000_0000, 1, 24'd4, 8'd0); // R9 collision with priority write
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [1:0] k;
            logic [31:0] d;
            r = $urandom % 10;
            k = 2'($urandom % 4);
            d = {rprio(), (k == 2'd1) ? {16'd0, rprio()} : rsrc()};
            if (r < 4)      step(0, k, d, 1, rsrc(), rprio());
            else if (r < 7) step(1, k, d, 0, 0, 0);
            else if (r < 9) step(1, k, d, 1, rsrc(), rprio());
            else            step(0, k, d, 0, 0, 0);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule